// File: doc/BRIEF.md
# Special Instruction Dispatch and Trap Assist

This block sits beside the issue stage of a processor that runs special instructions on accelerator datapaths loaded into a partially reconfigurable fabric. It keeps one small counter for each datapath type, holding how many instances of that type are loaded right now. A reconfiguration-complete event raises a counter and an unload event lowers it. Each counter change takes effect on its own, so an instruction can move to a faster implementation variant as soon as one more datapath finishes loading. It does not wait for the whole set.

When a special instruction issues, the block takes the opcode from the instruction word and looks the opcode up in a parameter table. The table lists, for each implementation variant, the minimum instance count needed of every datapath type. The block picks the best variant that the current counts allow and starts hardware execution with it. If no hardware variant is usable, because loading is not finished or because the instruction was never chosen for acceleration, the block raises a trap.

On a trap the block saves what the handler needs: the right-aligned opcode, both operand values and the destination register index. It then holds off further dispatch. When the handler returns, the block writes its result to the saved destination register.

Top module: `si_dispatch_assist`

## Requirements
- R1: Reset clears all instance counters to zero and drives exec_valid, trap, busy and wb_valid low. After reset, every opcode traps until a datapath has loaded.
- R2: A load event on type t raises counter t by one. An unload event on type t lowers it by one. Both events on the same type in one cycle leave counter t unchanged. A counter stays at 7 when raised and at 0 when lowered.
- R3: Among variants 1 to NUM_VAR-1, dispatch picks the highest-numbered variant whose per-type minimums are all met by the counts. A variant whose minimums are all zero is treated as absent. Variant 0 is the software fallback. The default table gives the following minimums per variant:
  - SI0: v1 t0>=1; v2 t0>=1,t1>=1; v3 t0>=2,t1>=1.
  - SI1: v1 t2>=1; v2 t1>=1,t2>=1; v3 t1,t2,t3>=1.
  - SI2: v1 t3>=1; v2 t3>=2; v3 t3>=4.
  - SI3: v1 t1>=1; v2 t0,t1,t2>=1; v3 absent.
- R4: When an issue is accepted and a variant is found, exec_valid is high for exactly one cycle, in the cycle after the issue. exec_variant carries the chosen index and exec_opcode carries instruction bits 28..24.
- R5: An accepted issue with no usable variant, or with an opcode of NUM_SI or above, raises trap for exactly one cycle, in the cycle after the issue, and never together with exec_valid.
- R6: On a trap, trap_opcode_word holds instruction bits 28..24 in bits 4..0, and all of its other bits are zero.
- R7: On a trap, trap_opa, trap_opb and trap_dest capture issue_opa, issue_opb and issue_dest. They keep these values until the next trap.
- R8: busy rises together with trap and stays high until a return strobe. While busy is high, an issue starts no execution, raises no trap and leaves the captured values unchanged.
- R9: A return strobe while busy clears busy. In the next cycle it gives a one-cycle wb_valid, with wb_dest equal to the captured destination and wb_data equal to ret_data. A return strobe while busy is low has no effect.
- R10: Dispatch uses the counter values from before any load or unload event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | A datapath instance finished loading |
| load_type | input | $clog2(NUM_TYPES) | Type of the loaded datapath |
| unload_valid | input | 1 | A datapath instance was removed |
| unload_type | input | $clog2(NUM_TYPES) | Type of the removed datapath |
| issue_valid | input | 1 | A special instruction issues |
| issue_instr | input | 32 | Instruction word, opcode in bits 28..24 |
| issue_opa | input | XLEN | First operand value |
| issue_opb | input | XLEN | Second operand value |
| issue_dest | input | RAW | Destination register index |
| exec_valid | output | 1 | Start hardware execution (pulse) |
| exec_variant | output | $clog2(NUM_VAR) | Chosen implementation variant |
| exec_opcode | output | 5 | Opcode being executed |
| trap | output | 1 | Unimplemented-instruction trap (pulse) |
| busy | output | 1 | Trap pending, dispatch held off |
| trap_opcode_word | output | 32 | Opcode right-aligned for the handler |
| trap_opa | output | XLEN | Saved first operand |
| trap_opb | output | XLEN | Saved second operand |
| trap_dest | output | RAW | Saved destination index |
| ret_valid | input | 1 | Handler return strobe |
| ret_data | input | XLEN | Result computed by the handler |
| wb_valid | output | 1 | Register write-back request (pulse) |
| wb_dest | output | RAW | Write-back register index |
| wb_data | output | XLEN | Write-back value |

## Verification
The counters cannot be seen from outside, so a wrong count shows up only at the next issue of an instruction that depends on that type. It then appears, one cycle after that issue, as a lower or higher exec_variant, or as a trap where execution was expected. The saturation corners are therefore driven past their limits and then stepped back by a known amount, so that a counter that wrapped would select a different variant. A stuck or missing busy shows up as a dropped dispatch or an extra trap in the cycle after a blocked issue. A wrong capture register shows up in the trap outputs or in the wb_dest and wb_data written one cycle after the return strobe.

// File: rtl/si_dispatch_assist.sv
module si_dispatch_assist #(
  parameter int XLEN      = 32,
  parameter int NUM_TYPES = 4,
  parameter int NUM_SI    = 4,
  parameter int NUM_VAR   = 4,
  parameter int RAW       = 5,
  parameter logic [2:0] REQ [NUM_SI][NUM_VAR][NUM_TYPES] = '{
    '{ '{0,0,0,0}, '{1,0,0,0}, '{1,1,0,0}, '{2,1,0,0} },
    '{ '{0,0,0,0}, '{0,0,1,0}, '{0,1,1,0}, '{0,1,1,1} },
    '{ '{0,0,0,0}, '{0,0,0,1}, '{0,0,0,2}, '{0,0,0,4} },
    '{ '{0,0,0,0}, '{0,1,0,0}, '{1,1,1,0}, '{0,0,0,0} }
  }
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_valid,
  input  logic [$clog2(NUM_TYPES)-1:0] load_type,
  input  logic                         unload_valid,
  input  logic [$clog2(NUM_TYPES)-1:0] unload_type,
  input  logic                         issue_valid,
  input  logic [31:0]                  issue_instr,
  input  logic [XLEN-1:0]              issue_opa,
  input  logic [XLEN-1:0]              issue_opb,
  input  logic [RAW-1:0]               issue_dest,
  output logic                         exec_valid,
  output logic [$clog2(NUM_VAR)-1:0]   exec_variant,
  output logic [4:0]                   exec_opcode,
  output logic                         trap,
  output logic                         busy,
  output logic [31:0]                  trap_opcode_word,
  output logic [XLEN-1:0]              trap_opa,
  output logic [XLEN-1:0]              trap_opb,
  output logic [RAW-1:0]               trap_dest,
  input  logic                         ret_valid,
  input  logic [XLEN-1:0]              ret_data,
  output logic                         wb_valid,
  output logic [RAW-1:0]               wb_dest,
  output logic [XLEN-1:0]              wb_data
);
  localparam int TW = $clog2(NUM_TYPES);
  localparam int VW = $clog2(NUM_VAR);
  localparam int SW = (NUM_SI > 1) ? $clog2(NUM_SI) : 1;

  logic [2:0]         cnt [NUM_TYPES];
  logic [4:0]         op;
  logic               op_ok;
  logic [SW-1:0]      si;
  logic [NUM_VAR-1:0] met;
  logic [VW-1:0]      sel;
  logic               hit;

  assign op    = issue_instr[28:24];
  assign op_ok = (32'(op) < NUM_SI);
  assign si    = op[SW-1:0];

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_cnt
    logic inc, dec;
    assign inc = load_valid   && (load_type   == TW'(g));
    assign dec = unload_valid && (unload_type == TW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                              cnt[g] <= '0;
      else if (inc && !dec && cnt[g] != 3'd7)  cnt[g] <= cnt[g] + 3'd1;
      else if (dec && !inc && cnt[g] != 3'd0)  cnt[g] <= cnt[g] - 3'd1;
    end
  end

  assign met[0] = 1'b0;
  for (genvar v = 1; v < NUM_VAR; v++) begin : g_var
    always_comb begin
      logic ok;
      logic any;
      ok  = op_ok;
      any = 1'b0;
      for (int t = 0; t < NUM_TYPES; t++) begin
        if (cnt[t] < REQ[si][v][t]) ok = 1'b0;
        if (REQ[si][v][t] != 3'd0)  any = 1'b1;
      end
      met[v] = ok && any;
    end
  end

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int v = 1; v < NUM_VAR; v++) begin
      if (met[v]) begin
        sel = VW'(v);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_valid       <= 1'b0;
      exec_variant     <= '0;
      exec_opcode      <= '0;
      trap             <= 1'b0;
      busy             <= 1'b0;
      trap_opcode_word <= '0;
      trap_opa         <= '0;
      trap_opb         <= '0;
      trap_dest        <= '0;
      wb_valid         <= 1'b0;
      wb_dest          <= '0;
      wb_data          <= '0;
    end else begin
      exec_valid <= 1'b0;
      trap       <= 1'b0;
      wb_valid   <= 1'b0;
      if (issue_valid && !busy) begin
        if (hit) begin
          exec_valid   <= 1'b1;
          exec_variant <= sel;
          exec_opcode  <= op;
        end else begin
          trap             <= 1'b1;
          busy             <= 1'b1;
          trap_opcode_word <= {27'b0, op};
          trap_opa         <= issue_opa;
          trap_opb         <= issue_opb;
          trap_dest        <= issue_dest;
        end
      end
      if (ret_valid && busy) begin
        busy     <= 1'b0;
        wb_valid <= 1'b1;
        wb_dest  <= trap_dest;
        wb_data  <= ret_data;
      end
    end
  end
endmodule

// File: rtl/si_dispatch_assist_chk.sv
module si_dispatch_assist_chk #(
  parameter int XLEN = 32,
  parameter int RAW  = 5,
  parameter int VW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [31:0]     issue_instr,
  input logic [RAW-1:0]  issue_dest,
  input logic            exec_valid,
  input logic [VW-1:0]   exec_variant,
  input logic            trap,
  input logic            busy,
  input logic [31:0]     trap_opcode_word,
  input logic [RAW-1:0]  trap_dest,
  input logic            ret_valid,
  input logic [XLEN-1:0] ret_data,
  input logic            wb_valid,
  input logic [RAW-1:0]  wb_dest,
  input logic [XLEN-1:0] wb_data
);
  assert_trap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);
  assert_trap_excl_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && exec_valid));
  assert_exec_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> $past(issue_valid && !busy));
  assert_exec_variant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> exec_variant != '0);
  assert_opcode_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> trap_opcode_word == {27'b0, $past(issue_instr[28:24])});
  assert_dest_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> trap_dest == $past(issue_dest));
  assert_trap_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> busy);
  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !trap && !exec_valid);
  assert_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ret_valid) |=> wb_valid && !busy && wb_data == $past(ret_data)
                             && wb_dest == $past(trap_dest));
  assert_wb_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(busy && ret_valid));
endmodule

bind si_dispatch_assist si_dispatch_assist_chk #(.XLEN(XLEN), .RAW(RAW), .VW(VW)) u_chk (.*);

// File: tb/sim_si_dispatch_assist.sv
module sim_si_dispatch_assist;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0, unload_valid = 1'b0;
  logic [1:0]  load_type = '0, unload_type = '0;
  logic        issue_valid = 1'b0;
  logic [31:0] issue_instr = '0, issue_opa = '0, issue_opb = '0;
  logic [4:0]  issue_dest = '0;
  logic        exec_valid, trap, busy, wb_valid;
  logic [1:0]  exec_variant;
  logic [4:0]  exec_opcode, trap_dest, wb_dest;
  logic [31:0] trap_opcode_word, trap_opa, trap_opb, wb_data;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_data = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  si_dispatch_assist u0 (.*);

  // kind[15:14] 0=issue 1=load 2=unload, arg[13:9], exp_trap[8], exp_var[7:6]
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0,5'd0,1'b1,2'd0,6'd0}, {2'd1,5'd0,1'b0,2'd0,6'd0},
    {2'd0,5'd0,1'b0,2'd1,6'd0}, {2'd1,5'd1,1'b0,2'd0,6'd0},
    {2'd0,5'd0,1'b0,2'd2,6'd0}, {2'd0,5'd3,1'b0,2'd1,6'd0},
    {2'd0,5'd1,1'b1,2'd0,6'd0}, {2'd1,5'd2,1'b0,2'd0,6'd0},
    {2'd0,5'd1,1'b0,2'd2,6'd0}, {2'd0,5'd3,1'b0,2'd2,6'd0},
    {2'd1,5'd0,1'b0,2'd0,6'd0}, {2'd0,5'd0,1'b0,2'd3,6'd0},
    {2'd0,5'd2,1'b1,2'd0,6'd0}, {2'd1,5'd3,1'b0,2'd0,6'd0},
    {2'd0,5'd2,1'b0,2'd1,6'd0}, {2'd0,5'd1,1'b0,2'd3,6'd0},
    {2'd1,5'd3,1'b0,2'd0,6'd0}, {2'd0,5'd2,1'b0,2'd2,6'd0},
    {2'd1,5'd3,1'b0,2'd0,6'd0}, {2'd1,5'd3,1'b0,2'd0,6'd0},
    {2'd0,5'd2,1'b0,2'd3,6'd0}, {2'd2,5'd1,1'b0,2'd0,6'd0},
    {2'd0,5'd0,1'b0,2'd1,6'd0}, {2'd0,5'd1,1'b0,2'd1,6'd0},
    {2'd0,5'd3,1'b1,2'd0,6'd0}, {2'd0,5'd9,1'b1,2'd0,6'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int t);
    load_valid = 1'b1; load_type = 2'(t);
    @(negedge clk); load_valid = 1'b0;
  endtask

  task automatic unload(input int t);
    unload_valid = 1'b1; unload_type = 2'(t);
    @(negedge clk); unload_valid = 1'b0;
  endtask

  task automatic issue(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] d);
    issue_valid = 1'b1;
    issue_instr = {3'b101, op, 24'h5A5A5A};
    issue_opa = a; issue_opb = b; issue_dest = d;
    @(negedge clk); issue_valid = 1'b0;
  endtask

  task automatic ret(input logic [31:0] data);
    ret_valid = 1'b1; ret_data = data;
    @(negedge clk); ret_valid = 1'b0;
  endtask

  task automatic expect_exec(input string req, input int v);
    check(req, {31'b0, exec_valid}, 1);
    check(req, {30'b0, exec_variant}, v);
    check(req, {31'b0, trap}, 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", {28'b0, exec_valid, trap, busy, wb_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [4:0] arg;
      kind = VEC[i][15:14];
      arg  = VEC[i][13:9];
      if (kind == 2'd1) load(int'(arg));
      else if (kind == 2'd2) unload(int'(arg));
      else begin
        issue(arg, 32'hA000_0000 + i, 32'h5000_0000 + i, 5'(i));
        if (VEC[i][8]) begin
          check("R5", {31'b0, trap}, 1);
          check("R5", {31'b0, exec_valid}, 0);
          check("R6", trap_opcode_word, {27'b0, arg});
          check("R7", trap_opa, 32'hA000_0000 + i);
          check("R7", trap_opb, 32'h5000_0000 + i);
          check("R7", {27'b0, trap_dest}, i);
          check("R8", {31'b0, busy}, 1);
          ret(32'hC0DE_0000 + i);
          check("R9", {31'b0, wb_valid}, 1);
          check("R9", {27'b0, wb_dest}, i);
          check("R9", wb_data, 32'hC0DE_0000 + i);
          check("R9", {31'b0, busy}, 0);
        end else begin
          expect_exec("R3", int'(VEC[i][7:6]));
          check("R4", {27'b0, exec_opcode}, {27'b0, arg});
          @(negedge clk);
          check("R4", {31'b0, exec_valid}, 0);
        end
      end
    end
    // counts now t0=2 t1=0 t2=1 t3=4
    // R2 lower saturation: wrap would give t3=7 -> variant 3
    repeat (6) unload(3);
    load(3);
    issue(5'd2, 0, 0, 0);
    expect_exec("R2", 1);
    // R2 upper saturation: wrap would give t3=5 -> variant 3
    repeat (10) load(3);
    repeat (6) unload(3);
    issue(5'd2, 0, 0, 0);
    expect_exec("R2", 1);
    // R2 same-type load and unload together: t3 stays 1
    load_valid = 1'b1; load_type = 2'd3; unload_valid = 1'b1; unload_type = 2'd3;
    @(negedge clk); load_valid = 1'b0; unload_valid = 1'b0;
    issue(5'd2, 0, 0, 0);
    expect_exec("R2", 1);
    // R2 different types together: t3=2, t0=1
    load_valid = 1'b1; load_type = 2'd3; unload_valid = 1'b1; unload_type = 2'd0;
    @(negedge clk); load_valid = 1'b0; unload_valid = 1'b0;
    issue(5'd2, 0, 0, 0);
    expect_exec("R2", 2);
    issue(5'd0, 0, 0, 0);
    expect_exec("R2", 1);
    // R10 unload in the issue cycle is not seen by that issue
    unload_valid = 1'b1; unload_type = 2'd3;
    issue(5'd2, 0, 0, 0);
    unload_valid = 1'b0;
    expect_exec("R10", 2);
    issue(5'd2, 0, 0, 0);
    expect_exec("R10", 1);
    // R8 issue while busy is dropped
    issue(5'd9, 32'h1111_1111, 32'h2222_2222, 5'd7);
    check("R5", {31'b0, trap}, 1);
    issue(5'd0, 32'h3333_3333, 32'h4444_4444, 5'd9);
    check("R8", {31'b0, exec_valid}, 0);
    check("R8", {31'b0, trap}, 0);
    check("R8", trap_opa, 32'h1111_1111);
    check("R8", {27'b0, trap_dest}, 7);
    check("R8", {31'b0, busy}, 1);
    ret(32'h0BAD_F00D);
    check("R9", {31'b0, wb_valid}, 1);
    check("R9", {27'b0, wb_dest}, 7);
    check("R9", wb_data, 32'h0BAD_F00D);
    // R9 return while idle does nothing
    ret(32'h7777_7777);
    check("R9", {31'b0, wb_valid}, 0);
    check("R9", wb_data, 32'h0BAD_F00D);
    // R1 reset clears counters
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1", {28'b0, exec_valid, trap, busy, wb_valid}, 0);
    issue(5'd0, 0, 0, 0);
    check("R1", {31'b0, trap}, 1);
    ret(0);
    summary();
  end
endmodule